// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Engine

This block is one DMA channel that executes a transfer control descriptor (TCD) held in eight 32-bit words. Software loads a descriptor and then starts it, either directly or by letting a peripheral pulse a hardware request line. Each start runs one inner (minor) loop. The minor loop moves a fixed byte count, one access element at a time, over a single-beat memory request/acknowledge bus. A wider element is split into 4-byte beats, and each beat is read and then written. After each element, the source and destination addresses step by their own signed offsets. An offset of zero holds a peripheral FIFO address fixed.

An outer (major) counter counts completed minor loops. When it runs out, the engine does the following:
- reloads the counter;
- sets done and can pulse an interrupt;
- can drop its hardware-request enable;
- either adds end-of-loop adjustments to both addresses, or fetches a chained descriptor from memory and may start it at once.

A descriptor whose sizes or counts cannot be executed raises an error flag instead of moving data.

Descriptor layout (word n sits at `tcd_word[32n+31:32n]` and, when chained, at byte address base+4n): w0 source address; w1 `[15:0]` signed source step, `[18:16]` source size code; w2 minor byte count; w3 source end adjustment; w4 destination address; w5 `[15:0]` signed destination step, `[18:16]` destination size code; w6 destination end adjustment or next-descriptor address; w7 `[24:16]` low nine and `[30:25]` high six bits of the major count, and flags `[0]` auto-start, `[1]` interrupt at completion, `[2]` interrupt at half count, `[3]` drop request enable at completion, `[4]` chain.

Top module: `dma_tcd_channel`

## Requirements
- R1: After reset, active, done, err, req_en, irq and mem_req are all low.
- R2: A minor loop moves w2 bytes as w2/E elements. Each element is issued as max(1,E/4) beats, and every beat is a read at src+4k followed by a write of the read data at dst+4k. mem_size is 0, 1 or 2 for 1-, 2- or 4-byte beats.
- R3: After each element, the source address advances by the sign-extended w1 step and the destination address by the sign-extended w5 step. A zero step keeps an address fixed, and a negative step lowers it.
- R4: Size code 0, 1, 2, 4 and 5 select E = 1, 2, 4, 16 and 32 bytes.
- R5: active is high from an accepted start until its minor loop ends. While the engine is busy (in a minor loop or a chained fetch), sw_start, hw_req and tcd_load are ignored.
- R6: The 15-bit major count drops by one per minor loop. On reaching zero it reloads from w7, sets done, and (chain off) adds w3 to the source and w6 to the destination. An accepted start clears done.
- R7: irq pulses for one cycle at major completion when flag 1 is set. It also pulses when flag 2 is set, the begin count is at least 2, and the count has just fallen to floor(begin/2).
- R8: hw_req starts a minor loop only while req_en is high. req_en_set raises req_en, and major completion with flag 3 clears it.
- R9: At major completion with flag 4 set, the engine reads eight words from the w6 address, replaces the descriptor with them, and starts a minor loop at once when the new flag 0 is set.
- R10: A start is refused and err is set, with no bus activity, when the two size codes differ, the code is not one of 0, 1, 2, 4 or 5, w2 is zero or not a multiple of E, or the major count is zero. tcd_load clears err and done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tcd_load | input | 1 | Load descriptor from tcd_word when idle |
| tcd_word | input | 256 | Descriptor, eight words |
| sw_start | input | 1 | Software start of one minor loop |
| hw_req | input | 1 | Peripheral request for one minor loop |
| req_en_set | input | 1 | Raise the request enable |
| mem_req | output | 1 | Bus beat request, held until acknowledged |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Beat byte address |
| mem_size | output | 2 | Beat size code 0/1/2 |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_ack | input | 1 | Beat accepted, read data valid |
| mem_rdata | input | 32 | Read data, right-justified |
| active | output | 1 | Minor loop in progress |
| done | output | 1 | Major loop completed |
| err | output | 1 | Descriptor refused |
| req_en | output | 1 | Hardware request enable |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench goes after these corner cases, each through every beat on the bus:
- 32-byte elements split into eight beats: a design that mishandled the split would write to the wrong beat offsets.
- A fixed source with an incrementing destination: a design that ignored a zero step would walk off the FIFO.
- A negative source step: a design that treated the offset as unsigned would jump 64 KB away.
- The half-count interrupt on an odd begin count: a wrong halving fires one loop early or late.
- Request-enable drop: a design that failed to clear req_en would start another loop on the next request.
- A chained descriptor that starts itself: an error here shows up as missing fetch reads or a stale address.
- Refused descriptors, which must leave the bus untouched.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    localparam int unsigned DTC_DW      = 32;
    localparam int unsigned DTC_WORDS   = 8;
    localparam int unsigned DTC_WIDX_W  = $clog2(DTC_WORDS);
    localparam int unsigned DTC_CNT_W   = 15;
    localparam int unsigned DTC_OFF_W   = 16;
    localparam int unsigned DTC_EB_W    = 6;
    localparam int unsigned DTC_BEAT_W  = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RD    = 2'd1,
        ST_WR    = 2'd2,
        ST_FETCH = 2'd3
    } dtc_state_e;

    typedef struct packed {
        dtc_state_e                          st;
        logic [DTC_WORDS-1:0][DTC_DW-1:0]    tcd;
        logic [DTC_DW-1:0]                   src;
        logic [DTC_DW-1:0]                   dst;
        logic [DTC_DW-1:0]                   left;
        logic [DTC_DW-1:0]                   hold;
        logic [DTC_DW-1:0]                   fbase;
        logic [DTC_CNT_W-1:0]                citer;
        logic [DTC_BEAT_W-1:0]               beat;
        logic [DTC_WIDX_W-1:0]               fidx;
        logic                                active;
        logic                                done;
        logic                                err;
        logic                                req_en;
        logic                                irq;
        logic                                pend;
    } dtc_regs_t;

    function automatic logic [DTC_EB_W-1:0] dtc_elem_bytes(input logic [2:0] code);
        case (code)
            3'd0:    return 6'd1;
            3'd1:    return 6'd2;
            3'd2:    return 6'd4;
            3'd4:    return 6'd16;
            3'd5:    return 6'd32;
            default: return 6'd0;
        endcase
    endfunction

endpackage

// File: rtl/dtc_size_check.sv
module dtc_size_check
    import dtc_pkg::*;
(
    input  logic [2:0]            src_code,
    input  logic [2:0]            dst_code,
    input  logic [DTC_DW-1:0]     nbytes,
    input  logic [DTC_CNT_W-1:0]  begin_cnt,
    output logic                  cfg_err,
    output logic [DTC_EB_W-1:0]   elem_bytes,
    output logic [1:0]            beat_code,
    output logic [DTC_BEAT_W-1:0] last_beat
);

    logic [DTC_EB_W-1:0] eb;
    logic [DTC_DW-1:0]   eb_mask;

    always_comb begin
        eb         = dtc_elem_bytes(src_code);
        eb_mask    = {{(DTC_DW-DTC_EB_W){1'b0}}, eb} - 32'd1;
        elem_bytes = eb;
        cfg_err    = (eb == '0) || (src_code != dst_code) || (nbytes == '0)
                   || ((nbytes & eb_mask) != '0) || (begin_cnt == '0);
        beat_code  = (src_code > 3'd2) ? 2'd2 : src_code[1:0];
        if (eb > 6'd4) begin
            last_beat = eb[DTC_BEAT_W+1:2] - 3'd1;
        end else begin
            last_beat = '0;
        end
    end

endmodule

// File: rtl/dtc_addr_adv.sv
module dtc_addr_adv #(
    parameter int unsigned AW = 32,
    parameter int unsigned OW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [OW-1:0] step,
    input  logic [AW-1:0] adj,
    input  logic          use_adj,
    output logic [AW-1:0] next
);

    logic [AW-1:0] step_x;

    always_comb begin
        step_x = {{(AW-OW){step[OW-1]}}, step};
        next   = base + step_x + (use_adj ? adj : '0);
    end

endmodule

// File: rtl/dma_tcd_channel.sv
module dma_tcd_channel
    import dtc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tcd_load,
    input  logic [255:0] tcd_word,
    input  logic         sw_start,
    input  logic         hw_req,
    input  logic         req_en_set,
    output logic         mem_req,
    output logic         mem_we,
    output logic [31:0]  mem_addr,
    output logic [1:0]   mem_size,
    output logic [31:0]  mem_wdata,
    input  logic         mem_ack,
    input  logic [31:0]  mem_rdata,
    output logic         active,
    output logic         done,
    output logic         err,
    output logic         req_en,
    output logic         irq
);

    localparam int unsigned CW = DTC_CNT_W;

    dtc_regs_t q, d;

    // descriptor field views
    logic [DTC_OFF_W-1:0] f_soff, f_doff;
    logic [2:0]           f_ssize, f_dsize;
    logic [DTC_DW-1:0]    f_nbytes, f_sadj, f_dadj;
    logic [CW-1:0]        f_begin;
    logic                 f_int_maj, f_int_half, f_dreq, f_chain;

    assign f_soff     = q.tcd[1][DTC_OFF_W-1:0];
    assign f_ssize    = q.tcd[1][18:16];
    assign f_nbytes   = q.tcd[2];
    assign f_sadj     = q.tcd[3];
    assign f_doff     = q.tcd[5][DTC_OFF_W-1:0];
    assign f_dsize    = q.tcd[5][18:16];
    assign f_dadj     = q.tcd[6];
    assign f_begin    = {q.tcd[7][30:25], q.tcd[7][24:16]};
    assign f_int_maj  = q.tcd[7][1];
    assign f_int_half = q.tcd[7][2];
    assign f_dreq     = q.tcd[7][3];
    assign f_chain    = q.tcd[7][4];

    logic                  cfg_err;
    logic [DTC_EB_W-1:0]   elem_bytes;
    logic [1:0]            beat_code;
    logic [DTC_BEAT_W-1:0] last_beat;

    dtc_size_check u_size (
        .src_code   (f_ssize),
        .dst_code   (f_dsize),
        .nbytes     (f_nbytes),
        .begin_cnt  (f_begin),
        .cfg_err    (cfg_err),
        .elem_bytes (elem_bytes),
        .beat_code  (beat_code),
        .last_beat  (last_beat)
    );

    logic [DTC_DW-1:0] elem_x;
    logic              last_elem, major_end;
    logic [CW-1:0]     cnt_dec;

    assign elem_x    = {{(DTC_DW-DTC_EB_W){1'b0}}, elem_bytes};
    assign last_elem = (q.left == elem_x);
    assign cnt_dec   = q.citer - {{(CW-1){1'b0}}, 1'b1};
    assign major_end = last_elem && (cnt_dec == '0);

    // source (0) and destination (1) address steppers
    logic [1:0][DTC_DW-1:0]    adv_base, adv_adj, adv_next;
    logic [1:0][DTC_OFF_W-1:0] adv_step;

    assign adv_base = {q.dst, q.src};
    assign adv_adj  = {f_dadj, f_sadj};
    assign adv_step = {f_doff, f_soff};

    for (genvar g = 0; g < 2; g++) begin : g_adv
        dtc_addr_adv #(.AW(DTC_DW), .OW(DTC_OFF_W)) u_adv (
            .base    (adv_base[g]),
            .step    (adv_step[g]),
            .adj     (adv_adj[g]),
            .use_adj (major_end && !f_chain),
            .next    (adv_next[g])
        );
    end

    logic              go;
    logic [DTC_DW-1:0] beat_off, fetch_off;

    assign go        = sw_start || (hw_req && q.req_en) || q.pend;
    assign beat_off  = {{(DTC_DW-DTC_BEAT_W-2){1'b0}}, q.beat, 2'b00};
    assign fetch_off = {{(DTC_DW-DTC_WIDX_W-2){1'b0}}, q.fidx, 2'b00};

    always_comb begin
        d     = q;
        d.irq = 1'b0;
        if (req_en_set) begin
            d.req_en = 1'b1;
        end
        unique case (q.st)
            ST_IDLE: begin
                if (tcd_load) begin
                    d.tcd   = tcd_word;
                    d.src   = tcd_word[31:0];
                    d.dst   = tcd_word[159:128];
                    d.citer = tcd_word[254:240];
                    d.done  = 1'b0;
                    d.err   = 1'b0;
                    d.pend  = 1'b0;
                end else if (go) begin
                    d.pend = 1'b0;
                    if (cfg_err) begin
                        d.err = 1'b1;
                    end else begin
                        d.active = 1'b1;
                        d.done   = 1'b0;
                        d.left   = f_nbytes;
                        d.beat   = '0;
                        d.st     = ST_RD;
                    end
                end
            end
            ST_RD: begin
                if (mem_ack) begin
                    d.hold = mem_rdata;
                    d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (mem_ack) begin
                    if (q.beat == last_beat) begin
                        d.beat = '0;
                        d.src  = adv_next[0];
                        d.dst  = adv_next[1];
                        d.left = q.left - elem_x;
                        if (last_elem) begin
                            d.active = 1'b0;
                            d.st     = ST_IDLE;
                            if (cnt_dec == '0) begin
                                d.citer = f_begin;
                                d.done  = 1'b1;
                                d.irq   = f_int_maj;
                                if (f_dreq) begin
                                    d.req_en = 1'b0;
                                end
                                if (f_chain) begin
                                    d.st    = ST_FETCH;
                                    d.fidx  = '0;
                                    d.fbase = f_dadj;
                                end
                            end else begin
                                d.citer = cnt_dec;
                                if (f_int_half && (f_begin > 15'd1)
                                    && (cnt_dec == (f_begin >> 1))) begin
                                    d.irq = 1'b1;
                                end
                            end
                        end else begin
                            d.st = ST_RD;
                        end
                    end else begin
                        d.beat = q.beat + 3'd1;
                        d.st   = ST_RD;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    d.tcd[q.fidx] = mem_rdata;
                    if (q.fidx == DTC_WIDX_W'(DTC_WORDS-1)) begin
                        d.st    = ST_IDLE;
                        d.src   = q.tcd[0];
                        d.dst   = q.tcd[4];
                        d.citer = mem_rdata[30:16];
                        d.pend  = mem_rdata[0];
                    end else begin
                        d.fidx = q.fidx + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        mem_req   = (q.st != ST_IDLE);
        mem_we    = (q.st == ST_WR);
        mem_wdata = q.hold;
        mem_size  = (q.st == ST_FETCH) ? 2'd2 : beat_code;
        case (q.st)
            ST_RD:    mem_addr = q.src + beat_off;
            ST_WR:    mem_addr = q.dst + beat_off;
            ST_FETCH: mem_addr = q.fbase + fetch_off;
            default:  mem_addr = '0;
        endcase
    end

    assign active = q.active;
    assign done   = q.done;
    assign err    = q.err;
    assign req_en = q.req_en;
    assign irq    = q.irq;

endmodule

// File: rtl/dtc_channel_chk.sv
module dtc_channel_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic [1:0]  mem_size,
    input logic        active,
    input logic        done,
    input logic        err,
    input logic        req_en,
    input logic        irq
);

    // R5 / R6: a running minor loop never shows done
    assert_active_not_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !done);

    // R2: an unacknowledged beat holds its request, direction and address
    assert_beat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4: beat size code is never the unused value 3
    assert_beat_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_size != 2'd3));

    // R7: interrupt pulses only once the minor loop has ended
    assert_irq_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !active);

    // R8: the request enable drops only at major completion
    assert_reqen_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_en) |-> done);

    // R10: a refused start issues no beat
    assert_err_no_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !mem_req);

endmodule

bind dma_tcd_channel dtc_channel_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .mem_size (mem_size),
    .active   (active),
    .done     (done),
    .err      (err),
    .req_en   (req_en),
    .irq      (irq)
);

// File: tb/dma_tcd_channel_tb_top.sv
`timescale 1ns/1ps
module dma_tcd_channel_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tcd_load = 1'b0;
    logic [255:0] tcd_word = '0;
    logic         sw_start = 1'b0;
    logic         hw_req = 1'b0;
    logic         req_en_set = 1'b0;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr, mem_wdata;
    logic [1:0]   mem_size;
    logic         mem_ack = 1'b0;
    logic [31:0]  mem_rdata = '0;
    logic         active, done, err, req_en, irq;

    always #2 clk = ~clk;

    dma_tcd_channel dut_i (.*);

    int n_chk = 0;
    int n_fail = 0;
    int irq_seen = 0;
    bit finished = 0;

    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [1:0]  size;
        logic [31:0] data;
    } beat_t;
    beat_t expq[$];
    logic [31:0] mem[int unsigned];

    // reference model state
    logic [31:0] m_src, m_dst, m_nb, m_sl, m_dl;
    logic [15:0] m_so, m_do;
    logic [2:0]  m_ss, m_ds;
    logic [4:0]  m_fl;
    int          m_biter, m_citer, m_irq;
    bit          m_done, m_err, m_reqen;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return (a * 32'h9E37_79B9) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] szmask(input logic [1:0] s);
        if (s == 2'd0) return 32'h0000_00FF;
        if (s == 2'd1) return 32'h0000_FFFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic int sb(input logic [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd4: return 16;
            3'd5: return 32;
            default: return 0;
        endcase
    endfunction

    function automatic logic [255:0] mk(input logic [31:0] s, input logic [31:0] d,
        input logic [15:0] so, input logic [15:0] dof, input logic [2:0] ss,
        input logic [2:0] ds, input logic [31:0] nb, input logic [31:0] sl,
        input logic [31:0] dl, input logic [14:0] mj, input logic [4:0] fl);
        logic [255:0] t;
        t = '0;
        t[31:0]    = s;
        t[63:32]   = {13'b0, ss, so};
        t[95:64]   = nb;
        t[127:96]  = sl;
        t[159:128] = d;
        t[191:160] = {13'b0, ds, dof};
        t[223:192] = dl;
        t[255:224] = {1'b0, mj, 11'b0, fl};
        return t;
    endfunction

    task automatic model_load(input logic [255:0] t);
        m_src = t[31:0];     m_so = t[47:32];   m_ss = t[50:48];
        m_nb  = t[95:64];    m_sl = t[127:96];  m_dst = t[159:128];
        m_do  = t[175:160];  m_ds = t[178:176]; m_dl = t[223:192];
        m_biter = int'(t[254:240]); m_citer = m_biter; m_fl = t[228:224];
    endtask

    task automatic m_minor();
        int e, nbeat;
        logic [1:0] bc;
        logic [255:0] t;
        e = sb(m_ss);
        if (e == 0 || m_ss != m_ds || m_nb == 0 || (m_nb % e) != 0 || m_biter == 0) begin
            m_err = 1;
            return;
        end
        m_done = 0;
        bc = (m_ss > 3'd2) ? 2'd2 : m_ss[1:0];
        nbeat = (e > 4) ? e / 4 : 1;
        for (int el = 0; el < int'(m_nb) / e; el++) begin
            for (int b = 0; b < nbeat; b++) begin
                beat_t r, w;
                r.we = 0; r.addr = m_src + 32'(4 * b); r.size = bc;
                r.data = pat(r.addr) & szmask(bc);
                w.we = 1; w.addr = m_dst + 32'(4 * b); w.size = bc; w.data = r.data;
                expq.push_back(r);
                expq.push_back(w);
            end
            m_src = m_src + {{16{m_so[15]}}, m_so};
            m_dst = m_dst + {{16{m_do[15]}}, m_do};
        end
        m_citer--;
        if (m_citer == 0) begin
            m_citer = m_biter;
            m_done = 1;
            if (m_fl[1]) m_irq++;
            if (m_fl[3]) m_reqen = 0;
            if (m_fl[4]) begin
                for (int i = 0; i < 8; i++) begin
                    beat_t f;
                    f.we = 0; f.addr = m_dl + 32'(4 * i); f.size = 2'd2; f.data = '0;
                    expq.push_back(f);
                    t[32*i +: 32] = pat(f.addr);
                end
                model_load(t);
                if (m_fl[0]) m_minor();
            end else begin
                m_src = m_src + m_sl;
                m_dst = m_dst + m_dl;
            end
        end else if (m_fl[2] && m_biter >= 2 && m_citer == m_biter / 2) begin
            m_irq++;
        end
    endtask

    // memory responder and per-beat comparison against the model
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req && !mem_ack && rst_n) begin
                mem_ack = 1'b1;
                if (expq.size() == 0) begin
                    chk("R2 unexpected beat at addr", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    beat_t e;
                    e = expq.pop_front();
                    chk("R2 beat direction", {31'b0, mem_we}, {31'b0, e.we});
                    chk("R2/R3 beat address", mem_addr, e.addr);
                    chk("R4 beat size", {30'b0, mem_size}, {30'b0, e.size});
                    if (mem_we) chk("R2 write data", mem_wdata, e.data);
                end
                if (mem_we) mem[mem_addr] = mem_wdata;
                else mem_rdata = pat(mem_addr) & szmask(mem_size);
            end else begin
                mem_ack = 1'b0;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (irq) irq_seen++;
        end
    end

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        report();
    end

    task automatic wait_idle();
        while (expq.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic status(input string tag);
        chk({tag, " done"}, {31'b0, done}, {31'b0, m_done});
        chk({tag, " err"}, {31'b0, err}, {31'b0, m_err});
        chk({tag, " req_en"}, {31'b0, req_en}, {31'b0, m_reqen});
        chk({tag, " irq count"}, irq_seen, m_irq);
        chk({tag, " active idle"}, {31'b0, active}, 32'd0);
        chk({tag, " queue drained"}, expq.size(), 0);
    endtask

    task automatic load(input logic [255:0] t);
        @(negedge clk);
        tcd_load = 1'b1; tcd_word = t;
        @(negedge clk);
        tcd_load = 1'b0;
        model_load(t);
        m_done = 0; m_err = 0;
    endtask

    task automatic kick();
        @(negedge clk);
        sw_start = 1'b1;
        m_minor();
        @(negedge clk);
        sw_start = 1'b0;
        wait_idle();
    endtask

    task automatic hreq();
        @(negedge clk);
        hw_req = 1'b1;
        if (m_reqen) m_minor();
        @(negedge clk);
        hw_req = 1'b0;
        wait_idle();
    endtask

    initial begin
        m_irq = 0; m_done = 0; m_err = 0; m_reqen = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 active", {31'b0, active}, 32'd0);
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 err", {31'b0, err}, 32'd0);
        chk("R1 req_en", {31'b0, req_en}, 32'd0);
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R6 R7: 4-byte copy, end adjustments rewind, second run repeats addresses
        load(mk(32'h1000, 32'h2000, 16'd4, 16'd4, 3'd2, 3'd2, 32'd16,
                -32'sd16, -32'sd16, 15'd1, 5'b00010));
        kick();
        status("R6 copy first");
        kick();
        status("R7 copy second");

        // R4 R2: 32-byte elements split into eight beats
        load(mk(32'h3000, 32'h4000, 16'd32, 16'd32, 3'd5, 3'd5, 32'd64,
                32'd0, 32'd0, 15'd1, 5'b0));
        kick();
        status("R4 32-byte");

        // R3: byte elements, differing steps
        load(mk(32'h5001, 32'h6000, 16'd1, 16'd2, 3'd0, 3'd0, 32'd3,
                32'd0, 32'd0, 15'd1, 5'b0));
        kick();
        status("R3 byte steps");

        // R3: negative source step with 2-byte elements
        load(mk(32'h7010, 32'h8000, 16'hFFFE, 16'd2, 3'd1, 3'd1, 32'd4,
                32'd0, 32'd0, 15'd1, 5'b0));
        kick();
        status("R3 negative step");

        // R8 R7 R6: fixed FIFO source, hardware requests, half interrupt, request drop
        load(mk(32'h9000, 32'hA000, 16'd0, 16'd4, 3'd2, 3'd2, 32'd8,
                32'd0, 32'd0, 15'd3, 5'b01110));
        hreq();
        status("R8 request while disabled");
        @(negedge clk); req_en_set = 1'b1; m_reqen = 1;
        @(negedge clk); req_en_set = 1'b0;
        hreq();
        status("R8 first request");
        hreq();
        status("R7 half count");
        hreq();
        status("R8 completion drop");
        hreq();
        status("R8 request after drop");

        // R5: second start while busy is ignored; major count 2 leaves done low
        load(mk(32'hF000, 32'hF800, 16'd4, 16'd4, 3'd2, 3'd2, 32'd16,
                32'd0, 32'd0, 15'd2, 5'b0));
        @(negedge clk); sw_start = 1'b1; m_minor();
        @(negedge clk); sw_start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 active during loop", {31'b0, active}, 32'd1);
        sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
        wait_idle();
        status("R5 busy start ignored");

        // R10: refused descriptors
        load(mk(32'h1100, 32'h1200, 16'd4, 16'd4, 3'd2, 3'd2, 32'd6,
                32'd0, 32'd0, 15'd1, 5'b0));
        kick();
        status("R10 count not multiple");
        load(mk(32'h1100, 32'h1200, 16'd4, 16'd4, 3'd2, 3'd1, 32'd8,
                32'd0, 32'd0, 15'd1, 5'b0));
        status("R10 load clears err");
        kick();
        status("R10 size mismatch");
        load(mk(32'h1100, 32'h1200, 16'd4, 16'd4, 3'd2, 3'd2, 32'd8,
                32'd0, 32'd0, 15'd0, 5'b0));
        kick();
        status("R10 zero major");

        // R9: chained descriptor fetched and auto-started
        begin
            logic [255:0] nxt;
            nxt = mk(32'hD000, 32'hE000, 16'd4, 16'd4, 3'd2, 3'd2, 32'd8,
                     32'd0, 32'd0, 15'd1, 5'b00011);
            for (int i = 0; i < 8; i++) mem[32'hC000 + 32'(4 * i)] = nxt[32*i +: 32];
        end
        load(mk(32'hB000, 32'hB800, 16'd4, 16'd4, 3'd2, 3'd2, 32'd4,
                32'd0, 32'hC000, 15'd1, 5'b10010));
        kick();
        status("R9 chain");

        report();
    end

endmodule